// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Sequencer

This block runs the acquisition buffer of a two-channel 8-bit sampling front end, so that every finished capture holds exactly as many samples from before the trigger as from after it. Each channel has its own circular store of 1024 bytes. The two stores share one write pointer and one read pointer, so they always move together. A sample-enable tick paces the writes.

A run goes through five phases:

- **Reset:** the buffer is empty and sampling is stopped.
- **Fill:** samples are stored and triggers are ignored until half the buffer is occupied.
- **Pre-sample:** each tick both writes a new sample and retires the oldest one, so the read side trails the write side by 512 and the store never fills.
- **Post-sample:** after a trigger the read pointer freezes and the remaining 512 slots fill up.
- **Retrieve:** the end-of-sampling flag rises, the sample gate closes, and the host steps through the capture, one stored pair per rising edge of its increment line.

The trigger can come from a comparator input, optionally inverted by a polarity select, or from a software force request. The trigger is armed only in the pre-sample phase and fires once. The current phase is reported on a 3-bit status output: 0 reset, 1 fill, 2 pre-sample, 3 post-sample, 4 retrieve.

Top module: `capture_sequencer`

## Requirements
- R1: While `rst_n` is low, the phase is 0, `eos` is 0 and `sample_gate` is 0, and the buffer is emptied. On the first clock edge after release, the phase becomes 1 (fill).
- R2: `rd_ch0` and `rd_ch1` always show the oldest unread sample pair. Pairs come out in the same order as the ticks that stored them.
- R3: In the fill phase every tick stores a pair and trigger inputs have no effect. The edge that stores the 512th pair also moves the phase to 2 (pre-sample).
- R4: In the pre-sample phase every tick stores a pair and retires the oldest one. The oldest unread pair is therefore always the one stored 512 ticks earlier, and the buffer never fills.
- R5: In the pre-sample phase, the clock edge at which (`trig_in` XOR `trig_invert`) OR `force_trig` is 1 moves the phase to 3 (post-sample).
- R6: In the post-sample phase the read side does not move and trigger inputs have no effect. The edge that stores the 512th pair after the trigger sets the phase to 4, sets `eos` to 1 and clears `sample_gate`.
- R7: While `eos` is 1, ticks store nothing and the stored data is unchanged.
- R8: In the retrieve phase, a rising edge of `host_inc` advances the read side by exactly one pair. The new pair appears on the third clock edge after `host_inc` is first sampled high. Holding `host_inc` high gives no further advance.
- R9: Outside the retrieve phase, `host_inc` has no effect on the read side.
- R10: Reads are blocked when the buffer is empty. After all 1024 pairs have been read, further increments leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; holding it low stops and empties the capture |
| sample_tick | input | 1 | Sample-enable tick, one pair per tick |
| ch0_data | input | 8 | Channel 0 sample |
| ch1_data | input | 8 | Channel 1 sample |
| trig_in | input | 1 | Comparator trigger input |
| trig_invert | input | 1 | Inverts `trig_in` before it reaches the trigger latch |
| force_trig | input | 1 | Software trigger request |
| host_inc | input | 1 | Host read-increment line, asynchronous |
| eos | output | 1 | End of sampling; capture ready to read |
| sample_gate | output | 1 | High while sampling is enabled (fill, pre-sample and post-sample phases) |
| rd_ch0 | output | 8 | Oldest unread channel 0 sample |
| rd_ch1 | output | 8 | Oldest unread channel 1 sample |
| phase | output | 3 | Current phase code (0 to 4) |

## Verification
Phase changes, `eos` and `sample_gate` respond on the same clock edge as the tick or trigger that causes them. Stored and retired data appear on the read outputs right after that edge. An increment takes effect only on the third edge after `host_inc` is first sampled, because it passes through a two-stage synchroniser and an edge detector. The bench drives inputs on the falling clock edge, advances its behavioural model on the rising edge, and compares every output on the following falling edge. Its point checks around increments look once after two edges, where no change is allowed yet, and again after the third edge, where the next pair must be visible.

// File: rtl/capture_sequencer.sv
module capture_sequencer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic [DATA_W-1:0] ch0_data,
  input  logic [DATA_W-1:0] ch1_data,
  input  logic              trig_in,
  input  logic              trig_invert,
  input  logic              force_trig,
  input  logic              host_inc,
  output logic              eos,
  output logic              sample_gate,
  output logic [DATA_W-1:0] rd_ch0,
  output logic [DATA_W-1:0] rd_ch1,
  output logic [2:0]        phase
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] ONE      = (AW+1)'(1);

  typedef enum logic [2:0] {
    PH_RST  = 3'd0,
    PH_FILL = 3'd1,
    PH_PRE  = 3'd2,
    PH_POST = 3'd3,
    PH_RETR = 3'd4
  } phase_t;

  phase_t            ph;
  logic [DATA_W-1:0] mem0 [DEPTH];
  logic [DATA_W-1:0] mem1 [DEPTH];
  logic [AW:0]       wr_ptr, rd_ptr, count;
  logic [2:0]        inc_sync;
  logic              empty, full, active, trig_hit, inc_pulse, wr_en, rd_en;

  assign count       = wr_ptr - rd_ptr;
  assign empty       = (count == '0);
  assign full        = (count == CNT_FULL);
  assign active      = (ph == PH_FILL) || (ph == PH_PRE) || (ph == PH_POST);
  assign trig_hit    = (trig_in ^ trig_invert) | force_trig;
  assign inc_pulse   = inc_sync[1] & ~inc_sync[2];
  assign wr_en       = sample_tick & active & ~full;
  assign rd_en       = ~empty & (((ph == PH_PRE) & sample_tick) |
                                 ((ph == PH_RETR) & inc_pulse));
  assign sample_gate = active;
  assign eos         = (ph == PH_RETR);
  assign phase       = ph;
  assign rd_ch0      = mem0[rd_ptr[AW-1:0]];
  assign rd_ch1      = mem1[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem0[wr_ptr[AW-1:0]] <= ch0_data;
      mem1[wr_ptr[AW-1:0]] <= ch1_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      inc_sync <= '0;
    end else begin
      inc_sync <= {inc_sync[1:0], host_inc};
      if (wr_en) wr_ptr <= wr_ptr + ONE;
      if (rd_en) rd_ptr <= rd_ptr + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_RST;
    end else begin
      unique case (ph)
        PH_RST:  ph <= PH_FILL;
        PH_FILL: if (wr_en && count == CNT_HALF - ONE) ph <= PH_PRE;
        PH_PRE:  if (trig_hit) ph <= PH_POST;
        PH_POST: if (wr_en && count == CNT_FULL - ONE) ph <= PH_RETR;
        default: ph <= PH_RETR;
      endcase
    end
  end

  a_r3_fill_read_still: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_FILL) |=> $stable(rd_ptr));
  a_r4_pre_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PRE) |-> (count == CNT_HALF));
  a_r6_post_read_still: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_POST) |=> $stable(rd_ptr));
  a_r7_no_write_after_eos: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> $stable(wr_ptr));
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RETR) |=> (rd_ptr == $past(rd_ptr)) || (rd_ptr == $past(rd_ptr) + ONE));
  a_r10_never_over: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);
endmodule

// File: tb/capture_sequencer_bench.sv
module capture_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sample_tick = 1'b0, trig_in = 1'b0, trig_invert = 1'b0;
  logic force_trig = 1'b0, host_inc = 1'b0;
  logic [7:0] ch0_data = '0, ch1_data = '0;
  logic eos, sample_gate;
  logic [7:0] rd_ch0, rd_ch1;
  logic [2:0] phase;

  int checks = 0, fails = 0, sn = 0;
  bit done = 1'b0;

  logic [7:0] q0[$], q1[$];
  int  mph = 0;
  bit  s1 = 0, s2 = 0, s3 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_sequencer u_capture_sequencer (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .ch0_data(ch0_data), .ch1_data(ch1_data), .trig_in(trig_in),
    .trig_invert(trig_invert), .force_trig(force_trig), .host_inc(host_inc),
    .eos(eos), .sample_gate(sample_gate), .rd_ch0(rd_ch0), .rd_ch1(rd_ch1),
    .phase(phase)
  );

  function automatic logic [7:0] g0(int n); return 8'(n) ^ 8'h5A; endfunction
  function automatic logic [7:0] g1(int n); return 8'(n * 37 + 11); endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit pulse;
    bit hit;
    if (!rst_n) begin
      q0.delete(); q1.delete(); mph = 0; s1 = 0; s2 = 0; s3 = 0;
      return;
    end
    pulse = s2 & ~s3;
    s3 = s2; s2 = s1; s1 = host_inc;
    hit = (trig_in ^ trig_invert) | force_trig;
    case (mph)
      0: mph = 1;
      1: if (sample_tick) begin
           q0.push_back(ch0_data); q1.push_back(ch1_data);
           if (q0.size() == 512) mph = 2;
         end
      2: begin
           if (sample_tick) begin
             q0.push_back(ch0_data); q1.push_back(ch1_data);
             void'(q0.pop_front()); void'(q1.pop_front());
           end
           if (hit) mph = 3;
         end
      3: if (sample_tick && q0.size() < 1024) begin
           q0.push_back(ch0_data); q1.push_back(ch1_data);
           if (q0.size() == 1024) mph = 4;
         end
      default: if (pulse && q0.size() > 0) begin
           void'(q0.pop_front()); void'(q1.pop_front());
         end
    endcase
  endtask

  task automatic compare();
    check(phase == 3'(mph), "R1/R3/R5/R6 phase", phase, mph);
    check(eos == (mph == 4), "R6 eos", eos, mph == 4);
    check(sample_gate == (mph >= 1 && mph <= 3), "R6 sample_gate", sample_gate,
          mph >= 1 && mph <= 3);
    if (q0.size() > 0) begin
      check(rd_ch0 == q0[0], "R2 rd_ch0", rd_ch0, q0[0]);
      check(rd_ch1 == q1[0], "R2 rd_ch1", rd_ch1, q1[0]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      sample_tick = 1'b1; ch0_data = g0(sn); ch1_data = g1(sn);
      step();
      sn++;
      sample_tick = 1'b0;
    end
  endtask

  task automatic run(bit use_force);
    int pf;
    logic [7:0] first0;
    rst_n = 1'b0; trig_in = 0; trig_invert = 0; force_trig = 0; host_inc = 0;
    step(); step(); step();
    check(phase == 0 && !eos && !sample_gate, "R1 held in reset", phase, 0);
    rst_n = 1'b1; sn = 0;
    step();
    check(phase == 1, "R1 fill after release", phase, 1);
    trig_in = 1; force_trig = 1;
    host_inc = 1; step(); step(); step(); step(); host_inc = 0;
    for (int k = 0; k < 7; k++) begin tick(73); step(); end
    check(phase == 1, "R3 triggers ignored in fill", phase, 1);
    check(rd_ch0 == g0(0), "R9 increment ignored in fill", rd_ch0, g0(0));
    trig_in = 0; force_trig = 0;
    tick(1);
    check(phase == 2, "R3 pre-sample at 512", phase, 2);
    tick(300);
    check(rd_ch0 == g0(sn - 512) && rd_ch1 == g1(sn - 512), "R4 trails by 512",
          rd_ch0, g0(sn - 512));
    host_inc = 1; step(); step(); step(); host_inc = 0; step(); step();
    check(rd_ch0 == g0(sn - 512), "R9 increment ignored in pre-sample", rd_ch0, g0(sn - 512));
    trig_invert = 1; trig_in = 1;
    step(); step(); step();
    check(phase == 2, "R5 inverted trigger stays low", phase, 2);
    if (use_force) begin trig_invert = 0; trig_in = 0; force_trig = 1; end
    else trig_in = 0;
    pf = sn - 512;
    step();
    force_trig = 0; trig_invert = 0;
    check(phase == 3, "R5 trigger fires", phase, 3);
    for (int k = 0; k < 511; k++) begin trig_in = k[0]; force_trig = k[1]; tick(1); end
    trig_in = 0; force_trig = 0;
    check(phase == 3 && rd_ch0 == g0(pf), "R6 read side frozen", rd_ch0, g0(pf));
    tick(1);
    check(phase == 4 && eos && !sample_gate, "R6 end of sampling", phase, 4);
    force_trig = 1; tick(5); force_trig = 0;
    check(rd_ch0 == g0(pf) && phase == 4, "R7 ticks ignored after eos", rd_ch0, g0(pf));
    first0 = g0(pf);
    for (int i = 0; i < 1024; i++) begin
      logic [7:0] nx;
      nx = (i == 1023) ? first0 : g0(pf + i + 1);
      check(rd_ch0 == g0(pf + i) && rd_ch1 == g1(pf + i), "R2 readout order", rd_ch0, g0(pf + i));
      host_inc = 1; step(); step();
      check(rd_ch0 == g0(pf + i), "R8 not before third edge", rd_ch0, g0(pf + i));
      step();
      check(rd_ch0 == nx, "R8 advance on third edge", rd_ch0, nx);
      step(); step();
      check(rd_ch0 == nx, "R8 held high advances once", rd_ch0, nx);
      host_inc = 0; step(); step();
    end
    for (int k = 0; k < 2; k++) begin
      host_inc = 1; step(); step(); step(); step(); host_inc = 0; step(); step();
    end
    check(rd_ch0 == first0, "R10 empty blocks reads", rd_ch0, first0);
  endtask

  initial begin
    @(negedge clk);
    run(1'b0);
    run(1'b1);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule